// File: doc/BRIEF.md
# PWM Audio Output Stage

This block turns 16-bit PCM samples into pulse-width-modulated waveforms, one output pin per channel, for an external low-pass filter. Software or a DMA engine writes samples through a small register bus. A control register sets the PWM resolution (8 or 10 bits), the pulse placement (leading edge, trailing edge or centred) and an optional MSB flip that turns two's-complement data into offset binary. It also sets a left pre-shift of 0 to 7 bits and how many PWM periods each sample is held.

A single holding register sits between the bus and the PWM engine. The block raises a request flag while this register is empty and the output is running, so a DMA engine can pace itself on it. A held sample passes to the active channel registers only at the end of a repeat group. If no new sample has arrived by then, the previous one is played again. While the output is stopped, a written sample is moved into the active registers on the next clock, so playback can be primed before it is started.

Top module: `pwm_audio_dac`

## Requirements
- R1: After reset the control register reads 0x0000_4008 (stopped, 8-bit, centred, one period per sample, MSB flip on, no shift), every PWM pin is low and `data_req` is low.
- R2: A write to byte offset 0x04 stores wdata[17:0] in the control register, and a read there returns it with bits 31:18 as zero. A read at offset 0x00 returns zero.
- R3: While control bit 0 (run) is clear, every PWM pin is low and the period and repeat counters are held at zero. After run is written to 1, the pin value belonging to phase 0 appears on the second rising edge.
- R4: Control bit 1 selects N = 8 (0) or N = 10 (1). An edge-aligned period lasts 2^N clocks and a centred period lasts 2^(N+1) clocks.
- R5: Control bits [3:2] set the placement, with k as the phase in the period, M = 2^N and c as the code. Value 0 drives high for k < c. Value 1 drives high for k >= M - c. Value 2 drives high for t < c, where t = k in the first half and t = 2M-1-k in the second half. Value 3 behaves as 0.
- R6: The code is formed as follows: flip bit 15 of the sample when control bit 14 is 1, shift left by control bits [17:15] within 16 bits, then take the top N bits.
- R7: A 32-bit data word carries channel 0 in bits 15:0 and channel 1 in bits 31:16.
- R8: Each sample is played for (control bits [12:4]) + 1 periods. A held sample is taken only when that group ends. With no new sample, the current code repeats.
- R9: `data_req` is high exactly when running with the holding register empty. A data write while the holding register is full is ignored.
- R10: While stopped, a held sample is converted with the current control value and moved to the channel registers on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W | Byte offset: 0x00 data, 0x04 control |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for `reg_addr`, combinational |
| data_req | output | 1 | Request for the next sample word |
| pwm_out | output | CHANNELS | One PWM pin per channel, registered |

## Verification
The assertions assume that the resolution, placement and repeat fields are changed only while run is clear. A change while running could leave the phase or repeat counter above a new, shorter limit for one period. The bench writes every configuration with run cleared, primes a sample, and then sets run with the same field values. Random configurations vary resolution, placement, MSB flip, shift and both channel samples. Directed runs cover the zero code, the full-scale code, overwrite of a full holding register and group-boundary latching.

// File: rtl/pad_pkg.sv
package pad_pkg;

    localparam int SAMPLE_W = 16;
    localparam int CODE_W   = 10;
    localparam int PHASE_W  = CODE_W + 1;
    localparam int REP_W    = 9;
    localparam int SHIFT_W  = 3;
    localparam int CTRL_W   = 18;

    typedef enum logic [1:0] {
        ALIGN_LEAD = 2'd0,
        ALIGN_TRAIL = 2'd1,
        ALIGN_MID  = 2'd2,
        ALIGN_RSVD = 2'd3
    } align_e;

    // bit 0 run, 1 resolution, 3:2 placement, 12:4 repeat-1, 13 flag, 14 flip, 17:15 shift
    typedef struct packed {
        logic [SHIFT_W-1:0] pre_shift;
        logic               msb_flip;
        logic               chg_flag;
        logic [REP_W-1:0]   rep_m1;
        align_e             align;
        logic               hi_res;
        logic               run;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        pre_shift: '0,
        msb_flip:  1'b1,
        chg_flag:  1'b0,
        rep_m1:    '0,
        align:     ALIGN_MID,
        hi_res:    1'b0,
        run:       1'b0
    };

    function automatic logic [CODE_W-1:0] make_code(logic [SAMPLE_W-1:0] s, ctrl_t c);
        logic [SAMPLE_W-1:0] v;
        v = s ^ {c.msb_flip, {(SAMPLE_W-1){1'b0}}};
        v = v << c.pre_shift;
        return c.hi_res ? v[SAMPLE_W-1 -: CODE_W] : {2'b00, v[SAMPLE_W-1 -: 8]};
    endfunction

    function automatic logic [PHASE_W-1:0] period_last(ctrl_t c);
        logic [1:0] sel;
        sel = {c.align == ALIGN_MID, c.hi_res};
        case (sel)
            2'b00:   return PHASE_W'(255);
            2'b01:   return PHASE_W'(1023);
            2'b10:   return PHASE_W'(511);
            default: return PHASE_W'(2047);
        endcase
    endfunction

endpackage

// File: rtl/pad_regs.sv
module pad_regs
    import pad_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              take,
    output ctrl_t             ctrl,
    output logic [BUS_W-1:0]  hold_word,
    output logic              hold_full,
    output logic              data_req
);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4);

    logic hit_data, hit_ctrl;
    assign hit_data = wr_en && (addr == OFS_DATA);
    assign hit_ctrl = wr_en && (addr == OFS_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= CTRL_RST;
            hold_word <= '0;
            hold_full <= 1'b0;
        end else begin
            if (hit_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (take) hold_full <= 1'b0;
            if (hit_data && !hold_full) begin
                hold_word <= wdata;
                hold_full <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL) rdata[CTRL_W-1:0] = ctrl;
    end

    assign data_req = ctrl.run && !hold_full;

endmodule

// File: rtl/pad_seq.sv
module pad_seq
    import pad_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic               hold_full,
    output logic [PHASE_W-1:0] phase,
    output logic [PHASE_W-1:0] last,
    output logic [CODE_W-1:0]  cmp_pos,
    output logic               grp_end,
    output logic               take
);
    logic [REP_W-1:0] rep_q;
    logic ph_end, rep_end;

    assign last    = period_last(ctrl);
    assign ph_end  = phase >= last;
    assign rep_end = rep_q >= ctrl.rep_m1;
    assign grp_end = ctrl.run && ph_end && rep_end;
    assign take    = hold_full && (!ctrl.run || grp_end);

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run) begin
            phase <= '0;
            rep_q <= '0;
        end else if (ph_end) begin
            phase <= '0;
            rep_q <= rep_end ? '0 : rep_q + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        if (ctrl.align == ALIGN_MID) begin
            if (ctrl.hi_res)
                cmp_pos = phase[CODE_W] ? ~phase[CODE_W-1:0] : phase[CODE_W-1:0];
            else
                cmp_pos = {2'b00, phase[8] ? ~phase[7:0] : phase[7:0]};
        end else begin
            cmp_pos = phase[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/pad_chan.sv
module pad_chan
    import pad_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  ctrl_t               ctrl,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                take,
    input  logic [CODE_W-1:0]   cmp_pos,
    output logic [CODE_W-1:0]   code_q,
    output logic                pwm_q
);
    logic [CODE_W:0] sum, full_scale;
    logic            hit;

    assign sum        = {1'b0, cmp_pos} + {1'b0, code_q};
    assign full_scale = ctrl.hi_res ? (CODE_W+1)'(1024) : (CODE_W+1)'(256);

    always_comb begin
        if (ctrl.align == ALIGN_TRAIL) hit = sum >= full_scale;
        else                           hit = cmp_pos < code_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            pwm_q  <= 1'b0;
        end else begin
            if (take) code_q <= make_code(sample, ctrl);
            pwm_q <= ctrl.run && hit;
        end
    end

endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
    import pad_pkg::*;
#(
    parameter int CHANNELS = 2,
    parameter int ADDR_W   = 3,
    parameter int BUS_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [BUS_W-1:0]    reg_wdata,
    output logic [BUS_W-1:0]    reg_rdata,
    output logic                data_req,
    output logic [CHANNELS-1:0] pwm_out
);
    localparam int CODES_W = CHANNELS * CODE_W;

    ctrl_t              ctrl;
    logic [BUS_W-1:0]   hold_word;
    logic               hold_full, take, grp_end, out_run, wr_data_hit;
    logic [PHASE_W-1:0] phase, last;
    logic [CODE_W-1:0]  cmp_pos;
    logic [CODES_W-1:0] code_flat;

    assign out_run     = ctrl.run;
    assign wr_data_hit = reg_wr && (reg_addr == '0);

    pad_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .take(take), .ctrl(ctrl), .hold_word(hold_word),
        .hold_full(hold_full), .data_req(data_req)
    );

    pad_seq u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .hold_full(hold_full), .phase(phase),
        .last(last), .cmp_pos(cmp_pos), .grp_end(grp_end), .take(take)
    );

    for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
        pad_chan u_chan (
            .clk(clk), .rst(rst), .ctrl(ctrl),
            .sample(hold_word[g*SAMPLE_W +: SAMPLE_W]), .take(take),
            .cmp_pos(cmp_pos), .code_q(code_flat[g*CODE_W +: CODE_W]),
            .pwm_q(pwm_out[g])
        );
    end

endmodule

// File: rtl/pad_chk.sv
module pad_chk
    import pad_pkg::*;
#(
    parameter int CHANNELS = 2,
    parameter int BUS_W    = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       run,
    input logic                       data_req,
    input logic                       wr_data_hit,
    input logic                       hold_full,
    input logic                       take,
    input logic [BUS_W-1:0]           hold_word,
    input logic [CHANNELS*CODE_W-1:0] code_flat,
    input logic [PHASE_W-1:0]         phase,
    input logic [PHASE_W-1:0]         last,
    input logic [CHANNELS-1:0]        pwm_out
);
    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |=> pwm_out == '0);                                          // R3
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (data_req && wr_data_hit) |=> !data_req);                         // R9
    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !take && wr_data_hit) |=> $stable(hold_word));      // R9
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> phase <= last);                                           // R4
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (run && !take) |=> $stable(code_flat));                           // R8
endmodule

bind pwm_audio_dac pad_chk #(.CHANNELS(CHANNELS), .BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst(rst), .run(out_run), .data_req(data_req),
    .wr_data_hit(wr_data_hit), .hold_full(hold_full), .take(take),
    .hold_word(hold_word), .code_flat(code_flat), .phase(phase),
    .last(last), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_audio_dac.sv
module tb_pwm_audio_dac;
    localparam int CLK_PERIOD = 10;
    localparam int CH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        data_req;
    logic [CH-1:0] pwm_out;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    pwm_audio_dac #(.CHANNELS(CH), .ADDR_W(3), .BUS_W(32)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_req(data_req),
        .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(bit run, bit res10, int align, int rep_m1,
                                            bit flip, int sh);
        return (32'(sh) << 15) | (32'(flip) << 14) | (32'(rep_m1) << 4) |
               (32'(align) << 2) | (32'(res10) << 1) | 32'(run);
    endfunction

    function automatic int exp_code(logic [15:0] s, bit flip, int sh, bit res10);
        logic [15:0] v;
        v = s ^ (flip ? 16'h8000 : 16'h0000);
        v = v << sh;
        return res10 ? int'(v[15:6]) : int'(v[15:8]);
    endfunction

    function automatic bit exp_bit(int k, int code, int align, bit res10);
        int m, t;
        m = res10 ? 1024 : 256;
        if (align == 2) begin
            t = (k < m) ? k : (2*m - 1 - k);
            return t < code;
        end
        if (align == 1) return k >= m - code;
        return k < code;
    endfunction

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_now(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // R4 R5 R6 R7 R10: prime while stopped, start, compare two full periods
    task automatic run_pattern(bit res10, int align, bit flip, int sh, logic [15:0] s0,
                               logic [15:0] s1);
        int len, c0, c1, bad0, bad1, k0, k1;
        len = (res10 ? 1024 : 256) * ((align == 2) ? 2 : 1);
        c0 = exp_code(s0, flip, sh, res10);
        c1 = exp_code(s1, flip, sh, res10);
        bad0 = 0; bad1 = 0; k0 = -1; k1 = -1;
        wr(3'd4, mk_ctrl(0, res10, align, 0, flip, sh));
        wr(3'd0, {s1, s0});
        wr(3'd4, mk_ctrl(1, res10, align, 0, flip, sh));
        for (int k = 0; k < 2*len; k++) begin
            @(negedge clk);
            if (pwm_out[0] != exp_bit(k % len, c0, align, res10)) begin
                bad0++; if (k0 < 0) k0 = k;
            end
            if (pwm_out[1] != exp_bit(k % len, c1, align, res10)) begin
                bad1++; if (k1 < 0) k1 = k;
            end
        end
        check(bad0 == 0, "R4 R5 R6 R10", $sformatf("ch0 pattern align=%0d res10=%0d code=%0d mism@%0d",
              align, res10, c0, k0), bad0, 0);
        check(bad1 == 0, "R5 R6 R7", $sformatf("ch1 pattern align=%0d res10=%0d code=%0d mism@%0d",
              align, res10, c1, k1), bad1, 0);
        wr(3'd4, mk_ctrl(0, res10, align, 0, flip, sh));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        int cnt [0:4][0:1];
        void'($urandom(32'h1A2B3C4D));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd4, d);
        check(d == 32'h0000_4008, "R1", "ctrl after reset", int'(d), 32'h4008);
        check(pwm_out == '0, "R1", "pwm after reset", int'(pwm_out), 0);
        check(data_req == 1'b0, "R1", "data_req after reset", int'(data_req), 0);

        // R2 readback
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d);
        check(d == 32'h0003_FFFF, "R2", "ctrl readback", int'(d), 32'h3FFFF);
        rd(3'd0, d);
        check(d == 32'h0, "R2", "data offset read", int'(d), 0);
        wr(3'd4, 32'h0);

        // directed corners: zero code, full scale, each placement
        run_pattern(1'b0, 0, 1'b1, 0, 16'h8000, 16'h8000);
        run_pattern(1'b1, 1, 1'b0, 0, 16'hFFFF, 16'h0040);
        run_pattern(1'b0, 2, 1'b1, 1, 16'h1234, 16'hC000);
        run_pattern(1'b1, 2, 1'b0, 7, 16'h0003, 16'h01FF);

        // random configurations
        for (int i = 0; i < 10; i++) begin
            run_pattern(1'($urandom % 2), int'($urandom % 3), 1'($urandom % 2),
                        int'($urandom % 8), 16'($urandom), 16'($urandom));
        end

        // R8 R9: repeat groups, boundary latching, request flag, ignored overwrite
        for (int p = 0; p < 5; p++) for (int c = 0; c < 2; c++) cnt[p][c] = 0;
        wr(3'd4, mk_ctrl(0, 0, 0, 2, 0, 0));
        wr(3'd0, {16'h2000, 16'h4000});
        wr(3'd4, mk_ctrl(1, 0, 0, 2, 0, 0));
        check(data_req == 1'b1, "R9", "req when running and empty", int'(data_req), 1);
        wr_now(3'd0, {16'h1000, 16'hC000});
        check(data_req == 1'b0, "R9", "req after fill", int'(data_req), 0);
        wr_now(3'd0, {16'h0100, 16'h0100});
        for (int g = 2; g < 5*256; g++) begin
            @(negedge clk);
            cnt[g/256][0] += int'(pwm_out[0]);
            cnt[g/256][1] += int'(pwm_out[1]);
            if (g == 766) check(data_req == 1'b0, "R8 R9", "req before group end", int'(data_req), 0);
            if (g == 768) check(data_req == 1'b1, "R8 R9", "req after group end", int'(data_req), 1);
        end
        for (int p = 1; p < 5; p++) begin
            check(cnt[p][0] == ((p < 3) ? 64 : 192), "R8 R9",
                  $sformatf("ch0 highs in period %0d", p), cnt[p][0], (p < 3) ? 64 : 192);
            check(cnt[p][1] == ((p < 3) ? 32 : 16), "R7 R8",
                  $sformatf("ch1 highs in period %0d", p), cnt[p][1], (p < 3) ? 32 : 16);
        end

        // R3 stopped output
        wr(3'd4, mk_ctrl(0, 0, 0, 0, 0, 0));
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                hi += int'(pwm_out != '0) + int'(data_req);
            end
            check(hi == 0, "R3", "pwm/req while stopped", hi, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule